// File: doc/BRIEF.md
# I2C Master Host Register Bank

This block is the software-facing side of a byte-oriented I2C master. A host reaches it through a byte-wide register port: a three-bit offset, a write strobe and a write byte, with read data returned combinationally for the offset presented. It holds a 16-bit clock prescaler, an enable and interrupt-enable pair, a transmit byte and the last received byte. It also holds a command register that can be written but not read, sharing its offset with a status register that can be read but not written.

On the engine side it issues one-cycle command pulses (start, stop, read, write) and a held NACK-select to a byte-level bus engine, which sits outside this block. It collects that engine's completion, arbitration-lost, busy, received-acknowledge and received-byte signals. Completion and arbitration loss latch an interrupt flag. The host clears the flag by setting the acknowledge bit in a command write, and that bit may be combined with new commands in the same byte.

Top module: `i2c_host_regs`

## Requirements
- R1: After reset the prescaler reads 0xFFFF, and the control byte, transmit byte, received byte, status byte, all command outputs and `irq_o` are 0.
- R2: Writes to offset 0 and offset 1 load the low and high prescaler bytes. Both bytes read back at the same offsets and drive `prescale_o`.
- R3: While control bit 7 is 1, writes to offsets 0 and 1 leave the prescaler unchanged.
- R4: Offset 2 stores bit 7 (core enable, driven on `core_en_o`) and bit 6 (interrupt enable). The other bits read 0.
- R5: A write to offset 3 sets `eng_txd_o`. A read of offset 3 returns `eng_rxd_i` as captured on the last cycle with `eng_done_i` high.
- R6: A write to offset 4 raises `eng_start_o`, `eng_stop_o`, `eng_read_o` and `eng_write_o` for exactly the following cycle, from bits 7, 6, 5 and 4 of the written byte.
- R7: Bit 3 of a command write drives `eng_nack_o`. The value holds until the next command write, or until `eng_done_i` clears it.
- R8: Status bit 1 (transfer in progress) sets on a command write with any of bits 7..4 set. It clears on `eng_done_i` or `eng_arb_lost_i`, and the set takes priority.
- R9: Status bit 0 (interrupt flag) sets on `eng_done_i` or `eng_arb_lost_i`. A command write with bit 0 set clears it, and a set in the same cycle takes priority.
- R10: `irq_o` is high exactly when the interrupt flag and control bit 6 are both 1.
- R11: Status bit 5 sets on `eng_arb_lost_i` and stays set until a command write with bit 7 set, with the set taking priority. Bit 6 follows `eng_busy_i` one cycle late. Bit 7 captures `eng_rxack_i` (1 = NACK) when `eng_done_i` is high. Bits 4..2 read 0.
- R12: The single command byte 0x91 starts a transfer with a write and clears a pending interrupt flag in the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Write byte |
| reg_rdata_o | output | 8 | Read byte for `reg_addr_i` |
| irq_o | output | 1 | Level interrupt |
| prescale_o | output | 16 | Clock prescaler value to engine |
| core_en_o | output | 1 | Engine enable |
| eng_start_o | output | 1 | Start-condition command pulse |
| eng_stop_o | output | 1 | Stop-condition command pulse |
| eng_read_o | output | 1 | Read-byte command pulse |
| eng_write_o | output | 1 | Write-byte command pulse |
| eng_nack_o | output | 1 | Send NACK after the read byte |
| eng_txd_o | output | 8 | Byte to transmit |
| eng_rxd_i | input | 8 | Byte received by engine |
| eng_rxack_i | input | 1 | Acknowledge seen from slave, 1 = NACK |
| eng_arb_lost_i | input | 1 | Arbitration lost pulse |
| eng_busy_i | input | 1 | Bus busy |
| eng_done_i | input | 1 | Command complete pulse |

## Verification
The hardest situations to reach are the same-cycle collisions: a completion or arbitration loss arriving in the very cycle the host writes a clearing or new command. In that cycle the set and clear priorities of the flag, the in-progress bit, the lost bit and the NACK-select all decide the outcome at once. The stimulus asserts completion and arbitration loss at random on every cycle, independently of the register operation, so these collisions occur many times. A directed sequence forces the done-with-acknowledge case and the combined 0x91 byte. A bench model updated at each edge predicts every output and every readable byte after every cycle.

// File: rtl/i2c_hr_pkg.sv
package i2c_hr_pkg;
  localparam int unsigned AW = 3;
  localparam int unsigned DW = 8;
  localparam int unsigned PW = 16;

  localparam logic [AW-1:0] OFS_PRE_LO = 3'd0;
  localparam logic [AW-1:0] OFS_PRE_HI = 3'd1;
  localparam logic [AW-1:0] OFS_CTRL   = 3'd2;
  localparam logic [AW-1:0] OFS_DATA   = 3'd3;
  localparam logic [AW-1:0] OFS_CMDST  = 3'd4;

  localparam int unsigned CTRL_EN  = 7;
  localparam int unsigned CTRL_IEN = 6;

  localparam int unsigned CMD_STA  = 7;
  localparam int unsigned CMD_WR   = 4;
  localparam int unsigned CMD_NACK = 3;
  localparam int unsigned CMD_IACK = 0;
  localparam int unsigned NOPS     = CMD_STA - CMD_WR + 1;

  typedef struct packed {
    logic       rxack;
    logic       busy;
    logic       al;
    logic [2:0] rsvd;
    logic       tip;
    logic       flag;
  } status_t;
endpackage

// File: rtl/i2c_hr_cfg.sv
module i2c_hr_cfg #(
  parameter int unsigned DW = 8,
  parameter int unsigned PW = 16,
  parameter logic [PW-1:0] PRE_RST = '1,
  localparam int unsigned NB = PW / DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] pre_we_i,
  input  logic          ctrl_we_i,
  input  logic          data_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [PW-1:0] prescale_o,
  output logic          en_o,
  output logic          ien_o,
  output logic [DW-1:0] txd_o
);
  logic en_q, ien_q;
  logic [DW-1:0] txd_q;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [DW-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_q <= PRE_RST[b*DW +: DW];
      else if (pre_we_i[b] && !en_q) lane_q <= wdata_i;
    end
    assign prescale_o[b*DW +: DW] = lane_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ien_q <= 1'b0;
      txd_q <= '0;
    end else begin
      if (ctrl_we_i) begin
        en_q  <= wdata_i[DW-1];
        ien_q <= wdata_i[DW-2];
      end
      if (data_we_i) txd_q <= wdata_i;
    end
  end

  assign en_o  = en_q;
  assign ien_o = ien_q;
  assign txd_o = txd_q;

  p_pre_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && (|pre_we_i)) |=> $stable(prescale_o));
endmodule

// File: rtl/i2c_hr_cmd.sv
module i2c_hr_cmd #(
  parameter int unsigned NOPS = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_we_i,
  input  logic [NOPS-1:0] op_i,
  input  logic            nack_i,
  input  logic            done_i,
  input  logic            arb_i,
  output logic [NOPS-1:0] pulse_o,
  output logic            nack_o,
  output logic            tip_o
);
  logic nack_q, tip_q;

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    logic p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) p_q <= 1'b0;
      else         p_q <= cmd_we_i & op_i[i];
    end
    assign pulse_o[i] = p_q;

    p_pulse_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (p_q && !(cmd_we_i && op_i[i])) |=> !pulse_o[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nack_q <= 1'b0;
      tip_q  <= 1'b0;
    end else begin
      if (cmd_we_i)    nack_q <= nack_i;
      else if (done_i) nack_q <= 1'b0;
      if (cmd_we_i && (|op_i))   tip_q <= 1'b1;
      else if (done_i || arb_i)  tip_q <= 1'b0;
    end
  end

  assign nack_o = nack_q;
  assign tip_o  = tip_q;

  p_nack_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_we_i && !done_i) |=> $stable(nack_o));
  p_tip_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && (|op_i)) |=> tip_o);
  p_tip_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_we_i && (done_i || arb_i)) |=> !tip_o);
endmodule

// File: rtl/i2c_hr_stat.sv
module i2c_hr_stat #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic          sta_i,
  input  logic          iack_i,
  input  logic          done_i,
  input  logic          arb_i,
  input  logic          busy_i,
  input  logic          rxack_i,
  input  logic [DW-1:0] rxd_i,
  output logic          flag_o,
  output logic          al_o,
  output logic          busy_o,
  output logic          rxack_o,
  output logic [DW-1:0] rxd_o
);
  logic flag_q, al_q, busy_q, rxack_q;
  logic [DW-1:0] rxd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      al_q    <= 1'b0;
      busy_q  <= 1'b0;
      rxack_q <= 1'b0;
      rxd_q   <= '0;
    end else begin
      // event sets win over host clears
      if (done_i || arb_i)          flag_q <= 1'b1;
      else if (cmd_we_i && iack_i)  flag_q <= 1'b0;
      if (arb_i)                    al_q <= 1'b1;
      else if (cmd_we_i && sta_i)   al_q <= 1'b0;
      busy_q <= busy_i;
      if (done_i) begin
        rxack_q <= rxack_i;
        rxd_q   <= rxd_i;
      end
    end
  end

  assign flag_o  = flag_q;
  assign al_o    = al_q;
  assign busy_o  = busy_q;
  assign rxack_o = rxack_q;
  assign rxd_o   = rxd_q;

  p_flag_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i || arb_i) |=> flag_o);
  p_flag_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && iack_i && !done_i && !arb_i) |=> !flag_o);
  p_al_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_i |=> al_o);
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
  import i2c_hr_pkg::*;
#(
  parameter logic [PW-1:0] PRE_RST = 16'hFFFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o,
  output logic [PW-1:0] prescale_o,
  output logic          core_en_o,
  output logic          eng_start_o,
  output logic          eng_stop_o,
  output logic          eng_read_o,
  output logic          eng_write_o,
  output logic          eng_nack_o,
  output logic [DW-1:0] eng_txd_o,
  input  logic [DW-1:0] eng_rxd_i,
  input  logic          eng_rxack_i,
  input  logic          eng_arb_lost_i,
  input  logic          eng_busy_i,
  input  logic          eng_done_i
);
  localparam int unsigned NB = PW / DW;

  logic [NB-1:0]   pre_we;
  logic            ctrl_we, data_we, cmd_we;
  logic            ien;
  logic [NOPS-1:0] pulse;
  logic [DW-1:0]   rxd;
  status_t         st;

  assign pre_we[0] = reg_we_i && (reg_addr_i == OFS_PRE_LO);
  assign pre_we[1] = reg_we_i && (reg_addr_i == OFS_PRE_HI);
  assign ctrl_we   = reg_we_i && (reg_addr_i == OFS_CTRL);
  assign data_we   = reg_we_i && (reg_addr_i == OFS_DATA);
  assign cmd_we    = reg_we_i && (reg_addr_i == OFS_CMDST);

  i2c_hr_cfg #(.DW(DW), .PW(PW), .PRE_RST(PRE_RST)) u_cfg (
    .clk_i, .rst_ni,
    .pre_we_i  (pre_we),
    .ctrl_we_i (ctrl_we),
    .data_we_i (data_we),
    .wdata_i   (reg_wdata_i),
    .prescale_o,
    .en_o      (core_en_o),
    .ien_o     (ien),
    .txd_o     (eng_txd_o)
  );

  i2c_hr_cmd #(.NOPS(NOPS)) u_cmd (
    .clk_i, .rst_ni,
    .cmd_we_i (cmd_we),
    .op_i     (reg_wdata_i[CMD_STA:CMD_WR]),
    .nack_i   (reg_wdata_i[CMD_NACK]),
    .done_i   (eng_done_i),
    .arb_i    (eng_arb_lost_i),
    .pulse_o  (pulse),
    .nack_o   (eng_nack_o),
    .tip_o    (st.tip)
  );

  i2c_hr_stat #(.DW(DW)) u_stat (
    .clk_i, .rst_ni,
    .cmd_we_i (cmd_we),
    .sta_i    (reg_wdata_i[CMD_STA]),
    .iack_i   (reg_wdata_i[CMD_IACK]),
    .done_i   (eng_done_i),
    .arb_i    (eng_arb_lost_i),
    .busy_i   (eng_busy_i),
    .rxack_i  (eng_rxack_i),
    .rxd_i    (eng_rxd_i),
    .flag_o   (st.flag),
    .al_o     (st.al),
    .busy_o   (st.busy),
    .rxack_o  (st.rxack),
    .rxd_o    (rxd)
  );

  assign st.rsvd = '0;

  assign eng_start_o = pulse[3];
  assign eng_stop_o  = pulse[2];
  assign eng_read_o  = pulse[1];
  assign eng_write_o = pulse[0];

  assign irq_o = st.flag & ien;

  always_comb begin
    unique case (reg_addr_i)
      OFS_PRE_LO: reg_rdata_o = prescale_o[DW-1:0];
      OFS_PRE_HI: reg_rdata_o = prescale_o[PW-1:DW];
      OFS_CTRL:   reg_rdata_o = {core_en_o, ien, {(DW-2){1'b0}}};
      OFS_DATA:   reg_rdata_o = rxd;
      OFS_CMDST:  reg_rdata_o = st;
      default:    reg_rdata_o = '0;
    endcase
  end

  p_irq_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ien);
  p_start_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && reg_wdata_i[CMD_STA]) |=> eng_start_o);
endmodule

// File: tb/i2c_host_regs_tb_top.sv
`timescale 1ns/1ps
module i2c_host_regs_tb_top;
  localparam int CLK_NS = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic irq_o, core_en_o, eng_start_o, eng_stop_o, eng_read_o, eng_write_o, eng_nack_o;
  logic [15:0] prescale_o;
  logic [7:0] eng_txd_o;
  logic [7:0] eng_rxd_i = '0;
  logic eng_rxack_i = 1'b0, eng_arb_lost_i = 1'b0, eng_busy_i = 1'b0, eng_done_i = 1'b0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  i2c_host_regs dut_i (.*);

  int n_chk = 0, n_err = 0;

  // reference model
  logic [15:0] m_pre = 16'hFFFF;
  logic m_en = 0, m_ien = 0, m_tip = 0, m_flag = 0, m_al = 0, m_busy = 0, m_rxack = 0, m_nack = 0;
  logic [7:0] m_txd = 0, m_rxd = 0;
  logic [3:0] m_pulse = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic model_step(input logic we, input logic [2:0] a, input logic [7:0] wd,
                            input logic dn, input logic ab, input logic bz,
                            input logic ak, input logic [7:0] rx);
    logic cw;
    cw = we && (a == 3'd4);
    m_pulse = cw ? wd[7:4] : 4'h0;
    if (cw) m_nack = wd[3]; else if (dn) m_nack = 1'b0;
    if (cw && (|wd[7:4])) m_tip = 1'b1; else if (dn || ab) m_tip = 1'b0;
    if (dn || ab) m_flag = 1'b1; else if (cw && wd[0]) m_flag = 1'b0;
    if (ab) m_al = 1'b1; else if (cw && wd[7]) m_al = 1'b0;
    m_busy = bz;
    if (dn) begin m_rxack = ak; m_rxd = rx; end
    if (we && a == 3'd0 && !m_en) m_pre[7:0]  = wd;
    if (we && a == 3'd1 && !m_en) m_pre[15:8] = wd;
    if (we && a == 3'd3) m_txd = wd;
    if (we && a == 3'd2) begin m_en = wd[7]; m_ien = wd[6]; end
  endtask

  task automatic cycle(input logic we, input logic [2:0] a, input logic [7:0] wd,
                       input logic dn, input logic ab, input logic bz,
                       input logic ak, input logic [7:0] rx);
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
    eng_done_i = dn; eng_arb_lost_i = ab; eng_busy_i = bz; eng_rxack_i = ak; eng_rxd_i = rx;
    model_step(we, a, wd, dn, ab, bz, ak, rx);
    @(posedge clk_i);
    #1;
    reg_we_i = 1'b0; eng_done_i = 1'b0; eng_arb_lost_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic check_all();
    logic [7:0] d;
    rd(3'd0, d); chk("R2 prescale low readback", d, m_pre[7:0]);
    rd(3'd1, d); chk("R2 prescale high readback", d, m_pre[15:8]);
    chk("R2 prescale_o", prescale_o, m_pre);
    rd(3'd2, d); chk("R4 control readback", d, {m_en, m_ien, 6'b0});
    chk("R4 core_en_o", core_en_o, m_en);
    chk("R5 eng_txd_o", eng_txd_o, m_txd);
    rd(3'd3, d); chk("R5 received byte", d, m_rxd);
    chk("R6 command pulses", {eng_start_o, eng_stop_o, eng_read_o, eng_write_o}, m_pulse);
    chk("R7 eng_nack_o", eng_nack_o, m_nack);
    rd(3'd4, d);
    chk("R8 tip bit", d[1], m_tip);
    chk("R9 flag bit", d[0], m_flag);
    chk("R11 al/busy/rxack/zero bits", {d[7:5], d[4:2]}, {m_rxack, m_busy, m_al, 3'b000});
    chk("R10 irq_o", irq_o, m_flag & m_ien);
    rd(3'd5, d); chk("R4 unmapped offset reads zero", d, 8'h00);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 prescale_o reset", prescale_o, 16'hFFFF);
    chk("R1 irq_o reset", irq_o, 1'b0);
    rd(3'd4, d); chk("R1 status reset", d, 8'h00);
    rd(3'd2, d); chk("R1 control reset", d, 8'h00);
    chk("R1 engine outputs reset",
        {eng_start_o, eng_stop_o, eng_read_o, eng_write_o, eng_nack_o, eng_txd_o}, 13'h0);
    check_all();

    // R2 load prescaler while disabled
    cycle(1, 3'd0, 8'h34, 0, 0, 0, 0, 8'h00);
    cycle(1, 3'd1, 8'h12, 0, 0, 0, 0, 8'h00);
    chk("R2 prescale 0x1234", prescale_o, 16'h1234);
    check_all();

    // R3 locked while enabled
    cycle(1, 3'd2, 8'hC0, 0, 0, 0, 0, 8'h00);
    cycle(1, 3'd0, 8'h55, 0, 0, 0, 0, 8'h00);
    cycle(1, 3'd1, 8'hAA, 0, 0, 0, 0, 8'h00);
    chk("R3 prescale unchanged while enabled", prescale_o, 16'h1234);
    check_all();

    // R9/R10 done sets flag, irq with ien
    cycle(0, 3'd0, 8'h00, 1, 0, 1, 1, 8'h5A);
    chk("R10 irq_o after done", irq_o, 1'b1);
    check_all();

    // R12 combined 0x91
    cycle(1, 3'd4, 8'h91, 0, 0, 1, 0, 8'h00);
    chk("R12 start pulse", eng_start_o, 1'b1);
    chk("R12 write pulse", eng_write_o, 1'b1);
    rd(3'd4, d); chk("R12 flag cleared, tip set", d[1:0], 2'b10);
    check_all();
    cycle(0, 3'd0, 8'h00, 0, 0, 1, 0, 8'h00);
    chk("R12 start pulse ends", {eng_start_o, eng_write_o}, 2'b00);
    check_all();

    // R9 done collides with iack: set wins
    cycle(1, 3'd4, 8'h29, 1, 0, 0, 1, 8'hC3);
    rd(3'd4, d); chk("R9 flag kept on done+iack", d[0], 1'b1);
    chk("R7 nack from same write", eng_nack_o, 1'b1);
    check_all();

    // R11 arbitration loss, cleared by start
    cycle(0, 3'd0, 8'h00, 0, 1, 0, 0, 8'h00);
    rd(3'd4, d); chk("R11 al set", d[5], 1'b1);
    cycle(1, 3'd4, 8'h81, 0, 0, 0, 0, 8'h00);
    rd(3'd4, d); chk("R11 al cleared by start", d[5], 1'b0);
    check_all();

    // random mix
    for (int it = 0; it < 1500; it++) begin
      int k;
      logic we;
      logic [2:0] a;
      logic [7:0] wd;
      k  = $urandom % 10;
      we = (k < 7);
      a  = (k < 5) ? 3'(k) : 3'd4;
      wd = 8'($urandom);
      if (a == 3'd2 && ($urandom % 2 == 0)) wd[7] = 1'b0;
      cycle(we, a, wd, ($urandom % 4) == 0, ($urandom % 12) == 0,
            1'($urandom), 1'($urandom), 8'($urandom));
      check_all();
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule